// File: doc/BRIEF.md
# Dual-Channel Event Counter

This block keeps two independent 48-bit event counters for a processor core. Each channel has a control register that picks one event code from a 6-bit code space and carries enable, run and clear bits plus a time-source select. Event sources arrive as a 64-bit vector of single-cycle strobes, where bit *n* is the strobe for event code *n*. One code counts elapsed time. It advances on every clock, or only on an external tick when the time-source bit is set.

Software programs a channel in two steps. It first writes the clear bit to zero the count. It then writes the event code together with enable and run. To stop a channel it writes zero to the control register, and the count is kept. Each count is read as a 16-bit high word and a 32-bit low word. Reading the high word freezes a copy of the low word, and the next low-word read of that channel returns the copy. A high-then-low read pair therefore always gives one consistent 48-bit value.

Top module: `evtctr_top`

## Requirements
- R1: After reset both control registers and both counts are zero, and `bus_rdata` is zero.
- R2: Control registers are at byte addresses 0x00 (channel 0) and 0x04 (channel 1). Bits 15 (enable), 14 (run), 8 (time source) and 5:0 (event code) read back as written. Bit 13 (clear) and all other bits, including bits 31:16, read as 0.
- R3: A count grows by exactly one on each cycle where the selected strobe `evt_i[code]` is high, and only while both enable and run are 1.
- R4: Code 0x23 counts elapsed time. With the time-source bit at 0 it increments on every cycle. With the bit at 1 it increments only on cycles where `tick_i` is high.
- R5: Codes 0x00, 0x0c, 0x1b through 0x20, 0x26 and every code above 0x29 never increment the count, whatever the strobes do.
- R6: A control write with bit 13 set zeroes the count on that clock edge. This takes priority over an increment due in the same cycle.
- R7: Writing zero to a control register stops the channel and keeps its count.
- R8: The count words are at 0x08 + 8·ch (high) and 0x0C + 8·ch (low). The high word reads {16'b0, count[47:32]} and the low word reads count[31:0]. Writes to count words have no effect.
- R9: A high-word read stores a copy of count[31:0]. The next low-word read of that channel returns the copy, and later low-word reads return the live value again.
- R10: The two channels are independent. Programming or strobes for one channel never change the other channel's count.
- R11: Read data appears on `bus_rdata` one clock after the read request. It holds its value through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_i | input | 64 | Event strobes, bit n is event code n |
| tick_i | input | 1 | External time tick for code 0x23 |

## Verification
A strobe sampled at one edge shows in the count register right after that edge. A control write takes effect at the edge where it is accepted, so counting under the new setting begins at the next edge. Read data is registered and holds the count as it stood before the request edge. The bench drives and samples only on falling edges and reads each result half a cycle after the edge that produced it. For the elapsed-time and snapshot cases it counts edges explicitly: the count runs from the edge after enable up to and including the disable edge, and back-to-back reads sit two edges apart.

// File: rtl/evtctr_pkg.sv
package evtctr_pkg;

    localparam int CODE_W     = 6;
    localparam int CTL_W      = 16;
    localparam int LO_W       = 32;
    localparam int BUS_W      = 32;

    localparam int CTL_EN_BIT   = 15;
    localparam int CTL_RUN_BIT  = 14;
    localparam int CTL_CLR_BIT  = 13;
    localparam int CTL_TSRC_BIT = 8;

    // bits that are stored; clear is an action, not state
    localparam logic [CTL_W-1:0] CTL_KEEP_MASK = 16'hC13F;

    localparam logic [CODE_W-1:0] CODE_ELAPSED = 6'h23;
    localparam logic [CODE_W-1:0] CODE_LAST    = 6'h29;

    function automatic logic code_assigned(input logic [CODE_W-1:0] c);
        logic ok;
        ok = (c != '0) && (c <= CODE_LAST);
        if (c == 6'h0c || c == 6'h26) ok = 1'b0;
        if (c >= 6'h1b && c <= 6'h20) ok = 1'b0;
        return ok;
    endfunction

endpackage

// File: rtl/evtctr_sel.sv
module evtctr_sel
    import evtctr_pkg::*;
#(
    parameter int EVT_N = 2**CODE_W
) (
    input  logic [CODE_W-1:0] code,
    input  logic              tsrc,
    input  logic [EVT_N-1:0]  evt_i,
    input  logic              tick_i,
    output logic              hit
);

    logic elapsed_hit;

    always_comb begin
        elapsed_hit = tsrc ? tick_i : 1'b1;
        if (!code_assigned(code)) begin
            hit = 1'b0;
        end else if (code == CODE_ELAPSED) begin
            hit = elapsed_hit;
        end else begin
            hit = evt_i[code];
        end
    end

endmodule

// File: rtl/evtctr_chan.sv
module evtctr_chan
    import evtctr_pkg::*;
#(
    parameter int CNT_W = 48,
    parameter int EVT_N = 2**CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              hi_rd,
    input  logic              lo_rd,
    input  logic [EVT_N-1:0]  evt_i,
    input  logic              tick_i,
    output logic [CTL_W-1:0]  ctl_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [LO_W-1:0]   lo_view_o
);

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        logic [CNT_W-1:0] cnt;
        logic [LO_W-1:0]  snap;
        logic             snap_vld;
    } chan_state_t;

    chan_state_t s_d, s_q;
    logic        hit;
    logic        active;

    evtctr_sel #(.EVT_N(EVT_N)) u_sel (
        .code   (s_q.ctl[CODE_W-1:0]),
        .tsrc   (s_q.ctl[CTL_TSRC_BIT]),
        .evt_i  (evt_i),
        .tick_i (tick_i),
        .hit    (hit)
    );

    always_comb begin
        s_d    = s_q;
        active = s_q.ctl[CTL_EN_BIT] & s_q.ctl[CTL_RUN_BIT];
        if (active && hit) begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end
        if (ctl_we) begin
            s_d.ctl = CTL_W'(wdata & BUS_W'(CTL_KEEP_MASK));
            if (wdata[CTL_CLR_BIT]) begin
                s_d.cnt = '0;
            end
        end
        if (hi_rd) begin
            s_d.snap     = s_q.cnt[LO_W-1:0];
            s_d.snap_vld = 1'b1;
        end else if (lo_rd) begin
            s_d.snap_vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctl_o     = s_q.ctl;
    assign cnt_o     = s_q.cnt;
    assign lo_view_o = s_q.snap_vld ? s_q.snap : s_q.cnt[LO_W-1:0];

endmodule

// File: rtl/evtctr_regif.sv
module evtctr_regif
    import evtctr_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int HI_W     = 16,
    parameter int CNT_BASE = 8,
    parameter int ADDR_W   = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_sel,
    input  logic                         bus_we,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [NUM_CH-1:0][CTL_W-1:0] ctl_all,
    input  logic [NUM_CH-1:0][HI_W-1:0]  hi_all,
    input  logic [NUM_CH-1:0][LO_W-1:0]  lo_all,
    output logic [NUM_CH-1:0]            ctl_we,
    output logic [NUM_CH-1:0]            hi_rd,
    output logic [NUM_CH-1:0]            lo_rd,
    output logic [BUS_W-1:0]             bus_rdata
);

    typedef struct packed {
        logic [BUS_W-1:0] rdata;
    } rif_state_t;

    rif_state_t r_d, r_q;
    logic [NUM_CH-1:0] ctl_hit, hi_hit, lo_hit;
    logic rd_req, wr_req;

    assign rd_req = bus_sel & ~bus_we;
    assign wr_req = bus_sel &  bus_we;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        localparam int CTL_A = 4 * i;
        localparam int HI_A  = CNT_BASE + 8 * i;
        localparam int LO_A  = CNT_BASE + 8 * i + 4;
        assign ctl_hit[i] = (bus_addr == ADDR_W'(CTL_A));
        assign hi_hit[i]  = (bus_addr == ADDR_W'(HI_A));
        assign lo_hit[i]  = (bus_addr == ADDR_W'(LO_A));
        assign ctl_we[i]  = wr_req & ctl_hit[i];
        assign hi_rd[i]   = rd_req & hi_hit[i];
        assign lo_rd[i]   = rd_req & lo_hit[i];
    end

    always_comb begin
        r_d = r_q;
        if (rd_req) begin
            r_d.rdata = '0;
            for (int i = 0; i < NUM_CH; i++) begin
                if (ctl_hit[i]) r_d.rdata = BUS_W'(ctl_all[i]);
                if (hi_hit[i])  r_d.rdata = BUS_W'(hi_all[i]);
                if (lo_hit[i])  r_d.rdata = BUS_W'(lo_all[i]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata = r_q.rdata;

endmodule

// File: rtl/evtctr_top.sv
module evtctr_top
    import evtctr_pkg::*;
#(
    parameter  int NUM_CH   = 2,
    parameter  int CNT_W    = 48,
    localparam int EVT_N    = 2**CODE_W,
    localparam int HI_W     = CNT_W - LO_W,
    localparam int CNT_BASE = ((4 * NUM_CH + 7) / 8) * 8,
    localparam int ADDR_W   = $clog2(CNT_BASE + 8 * NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [EVT_N-1:0]  evt_i,
    input  logic              tick_i
);

    logic [NUM_CH-1:0][CTL_W-1:0] ctl_w;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_w;
    logic [NUM_CH-1:0][HI_W-1:0]  hi_w;
    logic [NUM_CH-1:0][LO_W-1:0]  lo_w;
    logic [NUM_CH-1:0]            ctl_we_w, hi_rd_w, lo_rd_w;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        evtctr_chan #(.CNT_W(CNT_W), .EVT_N(EVT_N)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl_we    (ctl_we_w[i]),
            .wdata     (bus_wdata),
            .hi_rd     (hi_rd_w[i]),
            .lo_rd     (lo_rd_w[i]),
            .evt_i     (evt_i),
            .tick_i    (tick_i),
            .ctl_o     (ctl_w[i]),
            .cnt_o     (cnt_w[i]),
            .lo_view_o (lo_w[i])
        );
        assign hi_w[i] = cnt_w[i][CNT_W-1:LO_W];
    end

    evtctr_regif #(
        .NUM_CH   (NUM_CH),
        .HI_W     (HI_W),
        .CNT_BASE (CNT_BASE),
        .ADDR_W   (ADDR_W)
    ) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .ctl_all   (ctl_w),
        .hi_all    (hi_w),
        .lo_all    (lo_w),
        .ctl_we    (ctl_we_w),
        .hi_rd     (hi_rd_w),
        .lo_rd     (lo_rd_w),
        .bus_rdata (bus_rdata)
    );

endmodule

// File: rtl/evtctr_chk.sv
module evtctr_chk
    import evtctr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 48
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bus_sel,
    input logic                         bus_we,
    input logic [BUS_W-1:0]             bus_wdata,
    input logic [BUS_W-1:0]             bus_rdata,
    input logic [NUM_CH-1:0]            ctl_we,
    input logic [NUM_CH-1:0][CTL_W-1:0] ctl_all,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_all
);

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_we) |=> $stable(bus_rdata)); // R11

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ast
        AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_we[i] && bus_wdata[CTL_CLR_BIT]) |=> (cnt_all[i] == '0)); // R6

        AST_HALTED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!(ctl_all[i][CTL_EN_BIT] && ctl_all[i][CTL_RUN_BIT]) && !ctl_we[i])
            |=> (cnt_all[i] == $past(cnt_all[i]))); // R3

        AST_UNASSIGNED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!code_assigned(ctl_all[i][CODE_W-1:0]) && !ctl_we[i])
            |=> $stable(cnt_all[i])); // R5

        AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            !ctl_we[i] |=> ((cnt_all[i] == $past(cnt_all[i])) ||
                            (cnt_all[i] == $past(cnt_all[i]) + CNT_W'(1)))); // R3
    end

endmodule

bind evtctr_top evtctr_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ctl_we    (ctl_we_w),
    .ctl_all   (ctl_w),
    .cnt_all   (cnt_w)
);

// File: tb/tb_evtctr_top.sv
module tb_evtctr_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] evt_i = '0;
    logic        tick_i = 1'b0;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    evtctr_top dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_i(evt_i), .tick_i(tick_i)
    );

    localparam logic [31:0] EN   = 32'h8000;
    localparam logic [31:0] RUN  = 32'h4000;
    localparam logic [31:0] CLR  = 32'h2000;
    localparam logic [31:0] TSRC = 32'h0100;
    localparam int WIN = 8;

    typedef struct packed {
        logic       ch;
        logic [5:0] code;
        logic       tsrc;
        logic       en;
        logic       run;
        logic [3:0] pulses;
        logic [7:0] exp_cnt;
    } vec_t;

    // elapsed time without tick source: WIN + 2 edges between enable and disable
    localparam vec_t VEC [13] = '{
        '{1'b0, 6'h0a, 1'b0, 1'b1, 1'b1, 4'd5, 8'd5},
        '{1'b1, 6'h10, 1'b0, 1'b1, 1'b1, 4'd3, 8'd3},
        '{1'b0, 6'h08, 1'b0, 1'b1, 1'b0, 4'd4, 8'd0},
        '{1'b1, 6'h08, 1'b0, 1'b0, 1'b1, 4'd4, 8'd0},
        '{1'b0, 6'h0c, 1'b0, 1'b1, 1'b1, 4'd6, 8'd0},
        '{1'b1, 6'h1d, 1'b0, 1'b1, 1'b1, 4'd2, 8'd0},
        '{1'b0, 6'h26, 1'b0, 1'b1, 1'b1, 4'd7, 8'd0},
        '{1'b1, 6'h23, 1'b0, 1'b1, 1'b1, 4'd2, 8'd10},
        '{1'b0, 6'h23, 1'b1, 1'b1, 1'b1, 4'd3, 8'd3},
        '{1'b1, 6'h29, 1'b0, 1'b1, 1'b1, 4'd8, 8'd8},
        '{1'b0, 6'h01, 1'b0, 1'b1, 1'b1, 4'd1, 8'd1},
        '{1'b1, 6'h00, 1'b0, 1'b1, 1'b1, 4'd4, 8'd0},
        '{1'b0, 6'h30, 1'b0, 1'b1, 1'b1, 4'd4, 8'd0}
    };

    function automatic logic [4:0] a_ctl(input int ch); return 5'(4 * ch); endfunction
    function automatic logic [4:0] a_hi(input int ch);  return 5'(8 + 8 * ch); endfunction
    function automatic logic [4:0] a_lo(input int ch);  return 5'(12 + 8 * ch); endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d, v, keep;
        repeat (4) @(negedge clk);
        check("R1 rdata", bus_rdata, 32'h0);
        rst_n = 1'b1;
        for (int c = 0; c < 2; c++) begin
            rd(a_ctl(c), d); check("R1 ctl", d, 32'h0);
            rd(a_hi(c), d);  check("R1 hi", d, 32'h0);
            rd(a_lo(c), d);  check("R1 lo", d, 32'h0);
        end

        // table walk: R3 R4 R5 R7 R8
        for (int k = 0; k < 13; k++) begin
            vec_t t;
            t = VEC[k];
            wr(a_ctl(t.ch), CLR);
            wr(a_ctl(t.ch), (t.en ? EN : 0) | (t.run ? RUN : 0) |
                            (t.tsrc ? TSRC : 0) | 32'(t.code));
            for (int i = 0; i < WIN; i++) begin
                evt_i  = ~(64'd1 << t.code);
                if (i < int'(t.pulses)) evt_i[t.code] = 1'b1;
                tick_i = (i < int'(t.pulses));
                @(negedge clk);
            end
            evt_i = '0; tick_i = 1'b0;
            wr(a_ctl(t.ch), 32'h0);
            rd(a_hi(t.ch), d); check("R8 hi word", d, 32'h0);
            rd(a_lo(t.ch), d); check("R3/R4/R5 count", d, 32'(t.exp_cnt));
            rd(a_ctl(t.ch), d); check("R7 ctl after stop", d, 32'h0);
        end

        // R7: stopped channel keeps its count
        wr(a_ctl(1), CLR);
        wr(a_ctl(1), EN | RUN | 32'h0a);
        evt_i[8'h0a] = 1'b1; repeat (5) @(negedge clk); evt_i = '0;
        wr(a_ctl(1), 32'h0);
        evt_i[8'h0a] = 1'b1; repeat (6) @(negedge clk); evt_i = '0;
        rd(a_lo(1), d); check("R7 count kept", d, 32'd5);

        // R2: control readback mask
        wr(a_ctl(1), 32'hFFFF_FFFF);
        rd(a_ctl(1), d); check("R2 ctl mask", d, 32'h0000_C13F);
        wr(a_ctl(1), 32'h0);

        // R6: clear wins over a same-cycle increment
        wr(a_ctl(0), CLR);
        wr(a_ctl(0), EN | RUN | 32'h10);
        evt_i[8'h10] = 1'b1;
        repeat (3) @(negedge clk);
        wr(a_ctl(0), CLR | EN | RUN | 32'h10);
        evt_i = '0;
        rd(a_lo(0), d); check("R6 clear priority", d, 32'h0);
        rd(a_ctl(0), d); check("R2 clear reads 0", d, 32'h0000_C010);
        wr(a_ctl(0), 32'h0);

        // R10: channels independent
        wr(a_ctl(0), CLR); wr(a_ctl(1), CLR);
        wr(a_ctl(0), EN | RUN | 32'h10);
        wr(a_ctl(1), EN | RUN | 32'h0a);
        evt_i[8'h10] = 1'b1; repeat (3) @(negedge clk); evt_i = '0;
        evt_i[8'h0a] = 1'b1; repeat (2) @(negedge clk); evt_i = '0;
        wr(a_ctl(0), 32'h0); wr(a_ctl(1), 32'h0);
        rd(a_lo(0), d); check("R10 ch0", d, 32'd3);
        rd(a_lo(1), d); check("R10 ch1", d, 32'd2);

        // R9: snapshot on high read, reads two edges apart
        wr(a_ctl(1), CLR);
        wr(a_ctl(1), EN | RUN | 32'h23);
        repeat (3) @(negedge clk);
        rd(a_lo(1), v);
        rd(a_hi(1), d); check("R9 hi", d, 32'h0);
        rd(a_lo(1), d); check("R9 snapshot", d, v + 32'd2);
        rd(a_lo(1), d); check("R9 live after", d, v + 32'd6);

        // R8: writes to count words ignored
        wr(a_ctl(1), 32'h0);
        rd(a_lo(1), keep);
        wr(a_hi(1), 32'hFFFF_FFFF);
        wr(a_lo(1), 32'hFFFF_FFFF);
        rd(a_hi(1), d); check("R8 hi write ignored", d, 32'h0);
        rd(a_lo(1), d); check("R8 lo write ignored", d, keep);

        // R11: rdata holds through idle and writes
        rd(a_ctl(0), d);
        rd(a_lo(1), v);
        repeat (4) @(negedge clk);
        check("R11 hold idle", bus_rdata, v);
        wr(a_ctl(0), 32'h0000_8023);
        check("R11 hold write", bus_rdata, v);
        wr(a_ctl(0), 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule